// File: doc/BRIEF.md
# DDS Bit Clock and Frame Sync Generator

This block is the master-side timing source for a PCM voice port. It produces a serial bit clock and a frame sync pulse from one fast reference clock. The reference clock is also the design clock. The bit clock is the top bit of a phase accumulator that adds a tuning word on every reference cycle. Bit rates that do not divide the reference evenly therefore come out correct on average, with at most one reference cycle of edge jitter.

Two reference modes exist. In slow-reference mode the reference is taken as 4 MHz. A 2-bit select then chooses a 128, 256 or 512 kHz bit clock, and the frame rate is fixed at 8 kHz. In fast-reference mode the tuning word and the number of bit clocks per frame come straight from configuration inputs. In that mode a long sync pulse of 8 or 16 bit clocks may be requested. A low-jitter option, valid only at the fixed 8 kHz frame rate, pulls the accumulator back to phase zero once per frame. This makes every frame exactly the nominal number of reference cycles long.

The frame sync always changes in the same reference cycle as a rising bit-clock edge, so a receiver can sample it on the falling edge. Any change to the effective configuration restarts the generator. Both outputs then stay low until the first full frame begins.

Top module: `pcm_dds_clkgen`

## Requirements
- R1: While `rst` is high, and after it falls until the first frame begins, `bit_clk` and `frame_sync` are low.
- R2: With `cfg_fast_ref`=0 the tuning word is round(2^ACC_W · f / 4 MHz), where f = 128 kHz shifted left by `cfg_rate_sel`. Select value 3 acts as 2. Over whole frames, the measured `bit_clk` period matches 2^ACC_W / word within one reference cycle in total.
- R3: With `cfg_fast_ref`=0 a frame has f / 8 kHz bit clocks (16, 32 or 64). The sync is one bit clock wide, and `cfg_long_sync` and `cfg_long_16` have no effect.
- R4: With `cfg_fast_ref`=1 the tuning word is `cfg_tune_word`, and the frame length is `cfg_frame_bits`, with values below 2 treated as 2. The average `bit_clk` period matches 2^ACC_W / word within one reference cycle in total.
- R5: With `cfg_fast_ref`=1 the sync width is 1 bit clock when `cfg_long_sync`=0. When `cfg_long_sync`=1 it is 8 bit clocks if `cfg_long_16`=0 and 16 if `cfg_long_16`=1. The pulse starts at the first bit clock of the frame.
- R6: The sync width is limited to frame length minus one, so each frame keeps at least one bit clock with the sync low.
- R7: With `cfg_fast_ref`=0 and `cfg_low_jitter`=1, every frame lasts exactly 4 MHz / 8 kHz = 500 reference cycles. With `cfg_fast_ref`=1, `cfg_low_jitter` has no effect.
- R8: A change of the effective configuration (mode, word, frame length, sync width or low-jitter state) restarts the generator in the next cycle. Both outputs are low until the first rising `bit_clk` edge, and `frame_sync` is high on that edge. With word W, that edge is seen 2 + ceil(2^(ACC_W-1)/W) cycles after the change.
- R9: Outside a restart, `frame_sync` changes only in a reference cycle where `bit_clk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the design clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fast_ref | input | 1 | 0 = slow reference with fixed rate table, 1 = fast reference with programmable word |
| cfg_rate_sel | input | 2 | Slow-mode bit-rate select: 0 = 128 kHz, 1 = 256 kHz, 2 and 3 = 512 kHz |
| cfg_tune_word | input | ACC_W | Fast-mode phase increment |
| cfg_frame_bits | input | FRM_W | Fast-mode bit clocks per frame |
| cfg_long_sync | input | 1 | Fast mode: request a long sync pulse |
| cfg_long_16 | input | 1 | Long pulse length: 0 = 8, 1 = 16 bit clocks |
| cfg_low_jitter | input | 1 | Slow mode: realign the phase once per frame |
| bit_clk | output | 1 | Registered PCM bit clock |
| frame_sync | output | 1 | Registered PCM frame sync |

## Verification
The bench builds the block with ACC_W = 12 and FRM_W = 8, and treats its clock as the 4 MHz slow reference. A 12-bit accumulator cannot hit the slow-mode rates exactly: 128 kHz gives a word of 131, which makes a frame 500.27 cycles long. That leftover fraction makes the effect of the low-jitter realignment visible in frame periods, and also shows that the option is ignored in fast mode. The short word also lets the bench predict the cycle of the first edge after a restart by hand. The 8-bit frame field covers the 64-bit slow frame and the clamp cases at frame lengths 0, 2 and 4.

// File: rtl/pcm_dds_pkg.sv
package pcm_dds_pkg;

  typedef enum logic {
    REF_SLOW = 1'b0,
    REF_FAST = 1'b1
  } ref_mode_e;

  // Number of entries in the slow-mode rate table (2-bit select).
  localparam int SLOW_SEL_N = 4;
  // Highest select value with its own rate; larger values reuse it.
  localparam int SLOW_SEL_TOP = 2;

  // Rounded phase increment for f_out from f_ref with an acc_w-bit accumulator.
  function automatic longint unsigned dds_word(input int acc_w,
                                               input longint unsigned f_out,
                                               input longint unsigned f_ref);
    return ((f_out << acc_w) + (f_ref >> 1)) / f_ref;
  endfunction

  function automatic int slow_sel_clip(input int sel);
    return (sel > SLOW_SEL_TOP) ? SLOW_SEL_TOP : sel;
  endfunction

endpackage

// File: rtl/pcm_cfg_decode.sv
module pcm_cfg_decode
  import pcm_dds_pkg::*;
#(
  parameter int ACC_W        = 24,
  parameter int FRM_W        = 8,
  parameter int SLOW_REF_HZ  = 4_000_000,
  parameter int SLOW_BASE_HZ = 128_000,
  parameter int SYNC_HZ      = 8_000,
  parameter int SHORT_W      = 1,
  parameter int LONG_A_W     = 8,
  parameter int LONG_B_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_i,
  input  logic [1:0]       rate_sel_i,
  input  logic [ACC_W-1:0] tune_i,
  input  logic [FRM_W-1:0] frame_bits_i,
  input  logic             long_en_i,
  input  logic             long16_i,
  input  logic             low_jitter_i,
  output logic [ACC_W-1:0] tw_o,
  output logic [FRM_W-1:0] len_o,
  output logic [FRM_W-1:0] width_o,
  output logic             realign_o,
  output logic             restart_o
);

  localparam int SIG_W = 2 + ACC_W + 2 * FRM_W;
  localparam logic [FRM_W-1:0] MIN_LEN = FRM_W'(2);

  // Fixed slow-mode rate table, computed from the parameters.
  logic [ACC_W-1:0] slow_tw  [SLOW_SEL_N];
  logic [FRM_W-1:0] slow_len [SLOW_SEL_N];

  for (genvar k = 0; k < SLOW_SEL_N; k++) begin : g_slow
    localparam int              KC    = slow_sel_clip(k);
    localparam longint unsigned F_BIT = longint'(SLOW_BASE_HZ) << KC;
    localparam longint unsigned TW_K  = dds_word(ACC_W, F_BIT, longint'(SLOW_REF_HZ));
    localparam longint unsigned LEN_K = F_BIT / longint'(SYNC_HZ);
    assign slow_tw[k]  = ACC_W'(TW_K);
    assign slow_len[k] = FRM_W'(LEN_K);
  end

  ref_mode_e        mode;
  logic [ACC_W-1:0] tw_c;
  logic [FRM_W-1:0] fast_len, len_c, sel_w, lim, width_c;
  logic             realign_c;
  logic [SIG_W-1:0] sig_c, sig_q;

  assign mode = ref_mode_e'(fast_i);

  always_comb begin
    fast_len = (frame_bits_i < MIN_LEN) ? MIN_LEN : frame_bits_i;
    if (mode == REF_FAST) begin
      tw_c  = tune_i;
      len_c = fast_len;
      if (long_en_i) sel_w = long16_i ? FRM_W'(LONG_B_W) : FRM_W'(LONG_A_W);
      else           sel_w = FRM_W'(SHORT_W);
    end else begin
      tw_c  = slow_tw[rate_sel_i];
      len_c = slow_len[rate_sel_i];
      sel_w = FRM_W'(SHORT_W);
    end
    lim     = len_c - FRM_W'(1);
    width_c = (sel_w > lim) ? lim : sel_w;
  end

  assign realign_c = (mode == REF_SLOW) && low_jitter_i;
  assign sig_c     = {fast_i, realign_c, tw_c, len_c, width_c};

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig_c;
  end

  assign restart_o = (sig_c != sig_q);
  assign tw_o      = tw_c;
  assign len_o     = len_c;
  assign width_o   = width_c;
  assign realign_o = realign_c;

endmodule

// File: rtl/pcm_phase_acc.sv
module pcm_phase_acc #(
  parameter int ACC_W       = 24,
  parameter int REALIGN_CYC = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             realign_i,
  input  logic [ACC_W-1:0] tw_i,
  output logic             msb_o,
  output logic             rise_o
);

  localparam int              CNT_W = $clog2(REALIGN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REALIGN_CYC - 1);

  logic [ACC_W-1:0] acc_q;
  logic             msb_d_q;
  logic [CNT_W-1:0] tick_q;
  logic             wrap;

  assign wrap = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      acc_q   <= '0;
      msb_d_q <= 1'b0;
      tick_q  <= '0;
    end else begin
      tick_q  <= wrap ? '0 : tick_q + 1'b1;
      acc_q   <= (realign_i && wrap) ? '0 : acc_q + tw_i;
      msb_d_q <= acc_q[ACC_W-1];
    end
  end

  assign msb_o  = acc_q[ACC_W-1];
  assign rise_o = acc_q[ACC_W-1] & ~msb_d_q;

  // R7
  realign_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (realign_i && wrap) |=> (acc_q == '0));

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq #(
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             rise_i,
  input  logic             msb_i,
  input  logic [FRM_W-1:0] len_i,
  input  logic [FRM_W-1:0] width_i,
  output logic             bit_clk_o,
  output logic             sync_o
);

  logic             running_q, restart_d_q;
  logic [FRM_W-1:0] next_q, idx_q, idx_c;
  logic             clk_q, sync_q;

  assign idx_c = running_q ? next_q : '0;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      running_q <= 1'b0;
      next_q    <= '0;
      idx_q     <= '0;
      clk_q     <= 1'b0;
      sync_q    <= 1'b0;
    end else if (rise_i) begin
      running_q <= 1'b1;
      idx_q     <= idx_c;
      next_q    <= (idx_c >= len_i - FRM_W'(1)) ? '0 : idx_c + FRM_W'(1);
      clk_q     <= 1'b1;
      sync_q    <= (idx_c < width_i);
    end else begin
      clk_q     <= msb_i & running_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) restart_d_q <= 1'b0;
    else     restart_d_q <= restart_i;
  end

  assign bit_clk_o = clk_q;
  assign sync_o    = sync_q;

  // R9
  sync_rise_on_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> $rose(clk_q));

  // R9
  sync_fall_on_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_q) |-> ($rose(clk_q) || restart_d_q));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !running_q |-> (!clk_q && !sync_q));

  // R5
  sync_width_chk: assert property (@(posedge clk) disable iff (rst || restart_i)
    sync_q |-> (idx_q < width_i));

  // R3
  bit_index_range_chk: assert property (@(posedge clk) disable iff (rst || restart_i)
    running_q |-> (idx_q < len_i));

endmodule

// File: rtl/pcm_dds_clkgen.sv
module pcm_dds_clkgen #(
  parameter int ACC_W        = 24,
  parameter int FRM_W        = 8,
  parameter int SLOW_REF_HZ  = 4_000_000,
  parameter int SLOW_BASE_HZ = 128_000,
  parameter int SYNC_HZ      = 8_000,
  parameter int LONG_A_W     = 8,
  parameter int LONG_B_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_fast_ref,
  input  logic [1:0]       cfg_rate_sel,
  input  logic [ACC_W-1:0] cfg_tune_word,
  input  logic [FRM_W-1:0] cfg_frame_bits,
  input  logic             cfg_long_sync,
  input  logic             cfg_long_16,
  input  logic             cfg_low_jitter,
  output logic             bit_clk,
  output logic             frame_sync
);

  localparam int REALIGN_CYC = SLOW_REF_HZ / SYNC_HZ;

  logic [ACC_W-1:0] tw;
  logic [FRM_W-1:0] len, width;
  logic             realign, restart, msb, rise;

  pcm_cfg_decode #(
    .ACC_W(ACC_W), .FRM_W(FRM_W), .SLOW_REF_HZ(SLOW_REF_HZ),
    .SLOW_BASE_HZ(SLOW_BASE_HZ), .SYNC_HZ(SYNC_HZ), .SHORT_W(1),
    .LONG_A_W(LONG_A_W), .LONG_B_W(LONG_B_W)
  ) u_decode (
    .clk(clk), .rst(rst),
    .fast_i(cfg_fast_ref), .rate_sel_i(cfg_rate_sel), .tune_i(cfg_tune_word),
    .frame_bits_i(cfg_frame_bits), .long_en_i(cfg_long_sync), .long16_i(cfg_long_16),
    .low_jitter_i(cfg_low_jitter),
    .tw_o(tw), .len_o(len), .width_o(width), .realign_o(realign), .restart_o(restart)
  );

  pcm_phase_acc #(
    .ACC_W(ACC_W), .REALIGN_CYC(REALIGN_CYC)
  ) u_acc (
    .clk(clk), .rst(rst), .restart_i(restart), .realign_i(realign),
    .tw_i(tw), .msb_o(msb), .rise_o(rise)
  );

  pcm_frame_seq #(
    .FRM_W(FRM_W)
  ) u_frame (
    .clk(clk), .rst(rst), .restart_i(restart), .rise_i(rise), .msb_i(msb),
    .len_i(len), .width_i(width), .bit_clk_o(bit_clk), .sync_o(frame_sync)
  );

endmodule

// File: tb/tb_pcm_dds_clkgen.sv
module tb_pcm_dds_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 12;
  localparam int FRM_W      = 8;
  localparam int REF_HZ     = 4_000_000;
  localparam int BASE_HZ    = 128_000;
  localparam int SYNC_HZ    = 8_000;
  localparam int WD_CYCLES  = 150_000;
  localparam int NF         = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_fast_ref = 1'b0;
  logic [1:0]       cfg_rate_sel = '0;
  logic [ACC_W-1:0] cfg_tune_word = '0;
  logic [FRM_W-1:0] cfg_frame_bits = '0;
  logic             cfg_long_sync = 1'b0;
  logic             cfg_long_16 = 1'b0;
  logic             cfg_low_jitter = 1'b0;
  logic             bit_clk, frame_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  pcm_dds_clkgen #(.ACC_W(ACC_W), .FRM_W(FRM_W)) dut (
    .clk(clk), .rst(rst), .cfg_fast_ref(cfg_fast_ref), .cfg_rate_sel(cfg_rate_sel),
    .cfg_tune_word(cfg_tune_word), .cfg_frame_bits(cfg_frame_bits),
    .cfg_long_sync(cfg_long_sync), .cfg_long_16(cfg_long_16),
    .cfg_low_jitter(cfg_low_jitter), .bit_clk(bit_clk), .frame_sync(frame_sync)
  );

  typedef struct packed {
    logic       fast;
    logic [1:0] sel;
    logic [11:0] tw;
    logic [7:0] len;
    logic       long_en;
    logic       long16;
    logic [7:0] exp_len;
    logic [7:0] exp_wid;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 12'd0,    8'd0,  1'b0, 1'b0, 8'd16, 8'd1},
    '{1'b1, 2'd0, 12'd1000, 8'd16, 1'b0, 1'b0, 8'd16, 8'd1},
    '{1'b0, 2'd1, 12'd0,    8'd0,  1'b1, 1'b1, 8'd32, 8'd1},
    '{1'b1, 2'd0, 12'd1000, 8'd32, 1'b1, 1'b0, 8'd32, 8'd8},
    '{1'b0, 2'd2, 12'd0,    8'd0,  1'b0, 1'b0, 8'd64, 8'd1},
    '{1'b1, 2'd0, 12'd700,  8'd40, 1'b1, 1'b1, 8'd40, 8'd16},
    '{1'b0, 2'd3, 12'd0,    8'd0,  1'b0, 1'b0, 8'd64, 8'd1},
    '{1'b1, 2'd0, 12'd1500, 8'd4,  1'b1, 1'b1, 8'd4,  8'd3},
    '{1'b1, 2'd0, 12'd1200, 8'd0,  1'b0, 1'b0, 8'd2,  8'd1},
    '{1'b1, 2'd0, 12'd1100, 8'd2,  1'b1, 1'b0, 8'd2,  8'd1}
  };

  // Results of the last measurement.
  int m_lmin, m_lmax, m_wmin, m_wmax, m_pmin, m_pmax, m_span, m_moves;
  logic m_first_sync;

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_span(input string req, input int act, input real exp);
    real d;
    n_chk++;
    d = real'(act) - exp;
    if (d > 1.0 || d < -1.0) begin
      n_bad++;
      $display("FAIL %s clock span: actual %0d expected %0.3f", req, act, exp);
    end
  endtask

  function automatic int exp_tw(input logic fast, input logic [1:0] sel, input int tune);
    longint f;
    int s;
    if (fast) return tune;
    s = (sel == 2'd3) ? 2 : int'(sel);
    f = longint'(BASE_HZ) << s;
    return int'(((f << ACC_W) + longint'(REF_HZ / 2)) / longint'(REF_HZ));
  endfunction

  task automatic apply(input vec_t v);
    cfg_fast_ref   = v.fast;
    cfg_rate_sel   = v.sel;
    cfg_tune_word  = v.tw;
    cfg_frame_bits = v.len;
    cfg_long_sync  = v.long_en;
    cfg_long_16    = v.long16;
  endtask

  // Watch nf whole frames, sampling at falling edges.
  task automatic measure(input int nf);
    logic pc, ps_edge, prev_sync, seen;
    int fs, eif, hif, t0, tl;
    pc = 1'b0; ps_edge = 1'b0; prev_sync = 1'b0; seen = 1'b0;
    fs = -1; eif = 0; hif = 0; t0 = 0; tl = 0;
    m_lmin = 32'h7fffffff; m_lmax = 0; m_wmin = 32'h7fffffff; m_wmax = 0;
    m_pmin = 32'h7fffffff; m_pmax = 0; m_moves = 0; m_first_sync = 1'b0;
    while (fs < nf) begin
      @(negedge clk);
      if (bit_clk && !pc) begin
        if (!seen) begin
          seen = 1'b1;
          m_first_sync = frame_sync;
        end
        if (frame_sync && !ps_edge) begin
          if (fs >= 0) begin
            if (eif < m_lmin) m_lmin = eif;
            if (eif > m_lmax) m_lmax = eif;
            if (hif < m_wmin) m_wmin = hif;
            if (hif > m_wmax) m_wmax = hif;
            if (cyc - tl < m_pmin) m_pmin = cyc - tl;
            if (cyc - tl > m_pmax) m_pmax = cyc - tl;
          end else begin
            t0 = cyc;
          end
          fs++;
          tl = cyc; eif = 0; hif = 0;
        end
        if (fs >= 0) begin
          eif++;
          if (frame_sync) hif++;
        end
        ps_edge = frame_sync;
      end else if (frame_sync != prev_sync) begin
        m_moves++;
      end
      pc = bit_clk;
      prev_sync = frame_sync;
    end
    m_span = tl - t0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all R): actual %0d cycles expected fewer", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int tw, n, early;
    string rl, rw, rs;
    apply(VECS[0]);
    cfg_low_jitter = 1'b0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    // R1: outputs low under reset
    check_int("R1", "bit_clk in reset", int'(bit_clk), 0);
    check_int("R1", "frame_sync in reset", int'(frame_sync), 0);
    rst = 1'b0;
    @(negedge clk);
    check_int("R1", "bit_clk after reset", int'(bit_clk), 0);
    check_int("R1", "frame_sync after reset", int'(frame_sync), 0);

    // Table walk: R2..R6, R8 first-edge sync, R9 sync alignment
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      measure(NF);
      tw = exp_tw(VECS[i].fast, VECS[i].sel, int'(VECS[i].tw));
      rl = VECS[i].fast ? "R4" : "R3";
      rw = VECS[i].fast ? ((VECS[i].exp_wid < 8'd8 && VECS[i].long_en) ? "R6" : "R5") : "R3";
      rs = VECS[i].fast ? "R4" : "R2";
      check_int(rl, "frame length min", m_lmin, int'(VECS[i].exp_len));
      check_int(rl, "frame length max", m_lmax, int'(VECS[i].exp_len));
      check_int(rw, "sync width min", m_wmin, int'(VECS[i].exp_wid));
      check_int(rw, "sync width max", m_wmax, int'(VECS[i].exp_wid));
      check_span(rs, m_span, real'(NF * int'(VECS[i].exp_len)) * real'(1 << ACC_W) / real'(tw));
      check_int("R9", "sync moves off clock edge", m_moves, 0);
      check_int("R8", "sync on first edge", int'(m_first_sync), 1);
    end

    // R7: slow mode with realignment gives exact frames
    apply('{1'b0, 2'd0, 12'd0, 8'd0, 1'b0, 1'b0, 8'd16, 8'd1});
    cfg_low_jitter = 1'b1;
    measure(8);
    check_int("R7", "low-jitter frame period min", m_pmin, REF_HZ / SYNC_HZ);
    check_int("R7", "low-jitter frame period max", m_pmax, REF_HZ / SYNC_HZ);
    check_int("R7", "low-jitter frame length", m_lmax, 16);

    // R7: ignored in fast mode, same word drifts past 500
    apply('{1'b1, 2'd0, 12'd131, 8'd16, 1'b0, 1'b0, 8'd16, 8'd1});
    cfg_low_jitter = 1'b1;
    measure(8);
    check_int("R7", "fast mode ignores low jitter (period varies)",
              int'(m_pmin != REF_HZ / SYNC_HZ || m_pmax != REF_HZ / SYNC_HZ), 1);
    cfg_low_jitter = 1'b0;

    // R8: restart mid-frame, outputs low until first edge
    apply('{1'b1, 2'd0, 12'd1000, 8'd16, 1'b0, 1'b0, 8'd16, 8'd1});
    measure(1);
    repeat (7) @(negedge clk);
    cfg_tune_word = 12'd900;
    n = 0;
    early = 0;
    do begin
      @(negedge clk);
      n++;
      if (!bit_clk && frame_sync) early++;
    end while (!bit_clk && n < 40);
    check_int("R8", "cycles to first edge after change", n, 5);
    check_int("R8", "sync high on first edge", int'(frame_sync), 1);
    check_int("R8", "sync high before first edge", early, 0);

    summary();
    $finish;
  end

endmodule